// File: doc/BRIEF.md
# Block Waveform Generator

The block waveform generator produces test traffic for streaming datapaths. Each of its parallel streams owns a small writable waveform buffer of complex samples. Once enabled, the generator walks an address window in that buffer and emits the samples as fixed-length blocks. All streams move in lockstep. Each sample carries valid, block-start and block-end flags, a sync flag and a 64-bit block sequence number.

Software first loads the buffers through the buffer write port. It then programs eight control words through a write-only register port and sets the enable bit. The control words set the block length, the blocks per sync interval, the idle gap, the window bounds and the initial sequence number. A ready input lets the consumer pause the stream without losing or skipping samples. Clearing the enable stops the stream cleanly at the end of the block in progress.

Top module: `blkwave_gen`

## Requirements
- R1: After reset, out_valid, out_sop, out_eop and out_sync are all low.
- R2: Writing 1 to bit 0 of register index 0 starts generation. The first sample of the first block carries the sequence number {reg 7, reg 6}, where reg 7 is the upper 32 bits and reg 6 the lower 32 bits.
- R3: Register index 1 sets N, the samples per block, and a value of 0 acts as 1. out_sop marks the first valid sample of a block and out_eop marks the N-th.
- R4: Samples are read from consecutive buffer addresses, starting at register index 4 (window start). After the address in register index 5 (window end), reading returns to the start. The address runs on across block boundaries.
- R5: Register index 2 sets M, the blocks per sync interval, and a value of 0 acts as 1. out_sync is high on the first sample of block 0, M, 2M and so on of a run, and never without out_sop.
- R6: Register index 3 sets G. With ready held high, exactly G cycles with out_valid low separate an out_eop sample from the next out_sop sample. G = 0 gives back-to-back blocks.
- R7: out_bsn is constant within a block and rises by exactly 1 from one block to the next.
- R8: Clearing the enable bit lets the current block finish. After that, no further valid sample appears and no partial block is emitted.
- R9: A cycle with out_ready low at the clock edge produces no valid sample, and the stream resumes later without dropping or repeating a sample.
- R10: Every stream emits in lockstep from its own buffer. A buffer word is written with buf_wr, buf_sel (stream index) and buf_addr, with the real part in buf_wdata[31:16] and the imaginary part in buf_wdata[15:0].
- R11: Each new enable after a stop restarts the run. The sequence number reloads from its registers, the address returns to the window start and the sync count restarts.
- R12: out_sop, out_eop and out_sync are low whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_addr | input | 3 | Control register index |
| cfg_wdata | input | 32 | Control register write data |
| buf_wr | input | 1 | Waveform buffer write strobe |
| buf_sel | input | SEL_W (1) | Stream whose buffer is written |
| buf_addr | input | ADDR_W (6) | Buffer word address |
| buf_wdata | input | 2*SAMP_W (32) | Buffer word, real part upper, imaginary part lower |
| out_ready | input | 1 | Consumer accepts a sample this cycle |
| out_valid | output | 1 | Sample valid on all streams |
| out_sop | output | 1 | First sample of a block |
| out_eop | output | 1 | Last sample of a block |
| out_sync | output | 1 | First sample of a sync interval |
| out_bsn | output | 64 | Block sequence number |
| out_re | output | NSTR*SAMP_W (32) | Real parts, stream s at bits [s*SAMP_W +: SAMP_W] |
| out_im | output | NSTR*SAMP_W (32) | Imaginary parts, same layout |

## Verification
The hardest case to reach is a disable that lands when the consumer is stalling and the block is partly sent. The block must still finish, and nothing may follow it. The bench gets there with many random runs. Each run uses a random block length, window, gap and sync count, and toggles ready at random. The disable is written at a random cycle, so it falls in every phase of a block, including inside gaps and at block ends. Directed runs cover sequence-number carry from the low word into the high word, zero-valued length and sync count, and exact gap counts with ready held high.

// File: rtl/bwg_pkg.sv
// Package: shared definitions for the block waveform generator.
// Assumes nothing beyond SystemVerilog 2017.
package bwg_pkg;

    // Control register indices; the bench and software decode these
    localparam logic [2:0] REG_ENABLE  = 3'd0;
    localparam logic [2:0] REG_BLKLEN  = 3'd1;
    localparam logic [2:0] REG_SYNCBLK = 3'd2;
    localparam logic [2:0] REG_GAP     = 3'd3;
    localparam logic [2:0] REG_WSTART  = 3'd4;
    localparam logic [2:0] REG_WEND    = 3'd5;
    localparam logic [2:0] REG_BSN_LO  = 3'd6;
    localparam logic [2:0] REG_BSN_HI  = 3'd7;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EMIT = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bwg_regs.sv
// Module: control register file.
// Holds the enable, block shape, window and initial sequence number.
// Assumes ADDR_W and CNT_W do not exceed 32; writes take effect after the edge.
module bwg_regs
    import bwg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              en,
    output logic [CNT_W-1:0]  blk_len,
    output logic [CNT_W-1:0]  blk_per_sync,
    output logic [CNT_W-1:0]  gap_len,
    output logic [ADDR_W-1:0] win_start,
    output logic [ADDR_W-1:0] win_end,
    output logic [63:0]       bsn_init
);

    // Register writes decoded by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en           <= 1'b0;
            blk_len      <= CNT_W'(1);
            blk_per_sync <= CNT_W'(1);
            gap_len      <= '0;
            win_start    <= '0;
            win_end      <= '1;
            bsn_init     <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                REG_ENABLE:  en               <= cfg_wdata[0];
                REG_BLKLEN:  blk_len          <= cfg_wdata[CNT_W-1:0];
                REG_SYNCBLK: blk_per_sync     <= cfg_wdata[CNT_W-1:0];
                REG_GAP:     gap_len          <= cfg_wdata[CNT_W-1:0];
                REG_WSTART:  win_start        <= cfg_wdata[ADDR_W-1:0];
                REG_WEND:    win_end          <= cfg_wdata[ADDR_W-1:0];
                REG_BSN_LO:  bsn_init[31:0]   <= cfg_wdata;
                REG_BSN_HI:  bsn_init[63:32]  <= cfg_wdata;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/bwg_buf.sv
// Module: one stream's waveform buffer.
// Single write port and one registered read port. A read and a write to the
// same address in one cycle return the old word. Contents are not reset.
module bwg_buf #(
    parameter int ADDR_W = 6,
    parameter int SAMP_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*SAMP_W-1:0]   wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [SAMP_W-1:0]     rd_re,
    output logic [SAMP_W-1:0]     rd_im
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [2*SAMP_W-1:0] mem [DEPTH];
    logic [2*SAMP_W-1:0] rd_q;

    // Buffer load from the write port
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read, issued by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_re = rd_q[2*SAMP_W-1:SAMP_W];
    assign rd_im = rd_q[SAMP_W-1:0];

endmodule

// File: rtl/bwg_seq.sv
// Module: block sequencer.
// Walks the buffer window and counts samples, blocks and gap cycles. It issues
// one read per accepted cycle and registers the block flags, so they line up
// with the buffer's registered read data. It looks at the enable only at block
// ends and in gaps. Assumes the configuration is stable while a run is active.
module bwg_seq
    import bwg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CNT_W-1:0]  blk_len,
    input  logic [CNT_W-1:0]  blk_per_sync,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic [ADDR_W-1:0] win_start,
    input  logic [ADDR_W-1:0] win_end,
    input  logic [63:0]       bsn_init,
    input  logic              ready,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_sync,
    output logic [63:0]       o_bsn
);

    seq_state_e        state;
    logic [CNT_W-1:0]  samp_cnt;
    logic [CNT_W-1:0]  blk_cnt;
    logic [CNT_W-1:0]  gap_cnt;
    logic [ADDR_W-1:0] cur_addr;
    logic [63:0]       bsn;

    logic              issue;
    logic              first_samp;
    logic              last_samp;
    logic              last_blk;
    logic [ADDR_W-1:0] next_addr;

    // Per-cycle decisions from the counters
    always_comb begin
        issue      = (state == SQ_EMIT) && ready;
        first_samp = (samp_cnt == '0);
        last_samp  = ({1'b0, samp_cnt} + (CNT_W+1)'(1)) >= {1'b0, blk_len};
        last_blk   = ({1'b0, blk_cnt}  + (CNT_W+1)'(1)) >= {1'b0, blk_per_sync};
        next_addr  = (cur_addr == win_end) ? win_start : cur_addr + ADDR_W'(1);
    end

    assign rd_en   = issue;
    assign rd_addr = cur_addr;

    // Run state, counters, address and sequence number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            samp_cnt <= '0;
            blk_cnt  <= '0;
            gap_cnt  <= '0;
            cur_addr <= '0;
            bsn      <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (en) begin
                        state    <= SQ_EMIT;
                        samp_cnt <= '0;
                        blk_cnt  <= '0;
                        cur_addr <= win_start;
                        bsn      <= bsn_init;
                    end
                end
                SQ_EMIT: begin
                    if (ready) begin
                        cur_addr <= next_addr;
                        if (last_samp) begin
                            samp_cnt <= '0;
                            bsn      <= bsn + 64'd1;
                            blk_cnt  <= last_blk ? '0 : blk_cnt + CNT_W'(1);
                            if (!en) begin
                                state <= SQ_IDLE;
                            end else if (gap_len != '0) begin
                                state   <= SQ_GAP;
                                gap_cnt <= gap_len;
                            end
                        end else begin
                            samp_cnt <= samp_cnt + CNT_W'(1);
                        end
                    end
                end
                SQ_GAP: begin
                    if (gap_cnt <= CNT_W'(1)) state <= en ? SQ_EMIT : SQ_IDLE;
                    else                      gap_cnt <= gap_cnt - CNT_W'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Output flags aligned with the registered buffer read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_sop   <= 1'b0;
            o_eop   <= 1'b0;
            o_sync  <= 1'b0;
            o_bsn   <= '0;
        end else begin
            o_valid <= issue;
            o_sop   <= issue && first_samp;
            o_eop   <= issue && last_samp;
            o_sync  <= issue && first_samp && (blk_cnt == '0);
            if (issue) o_bsn <= bsn;
        end
    end

    // R5: sync only marks the first sample of a block
    p_sync_on_sop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        o_sync |-> o_sop);

    // R12: no block flag without a valid sample
    p_flags_need_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sop || o_eop || o_sync) |-> o_valid);

    // R7: during a run the sequence number only steps by one
    p_bsn_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != SQ_IDLE) && ($past(state) != SQ_IDLE) && (bsn != $past(bsn)))
        |-> (bsn == $past(bsn) + 64'd1));

    // R4: reads stay inside an ordered window
    p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (win_start <= win_end))
        |-> ((cur_addr >= win_start) && (cur_addr <= win_end)));

    // R6: a nonzero gap forces an idle cycle after a block end
    p_gap_after_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_eop && ($past(gap_len) != '0)) |=> !o_valid);

    // R8: a block that ends while disabled is the last one
    p_stop_at_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_eop && !$past(en)) |=> !o_valid);

endmodule

// File: rtl/blkwave_gen.sv
// Module: block waveform generator top.
// Joins the register file, one buffer per stream and the shared sequencer.
// Assumes buffers are loaded and registers set while generation is stopped.
module blkwave_gen
    import bwg_pkg::*;
#(
    parameter int NSTR   = 2,
    parameter int SAMP_W = 16,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16,
    localparam int SEL_W = (NSTR > 1) ? $clog2(NSTR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [2:0]               cfg_addr,
    input  logic [31:0]              cfg_wdata,
    input  logic                     buf_wr,
    input  logic [SEL_W-1:0]         buf_sel,
    input  logic [ADDR_W-1:0]        buf_addr,
    input  logic [2*SAMP_W-1:0]      buf_wdata,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic                     out_sync,
    output logic [63:0]              out_bsn,
    output logic [NSTR*SAMP_W-1:0]   out_re,
    output logic [NSTR*SAMP_W-1:0]   out_im
);

    logic              en;
    logic [CNT_W-1:0]  blk_len;
    logic [CNT_W-1:0]  blk_per_sync;
    logic [CNT_W-1:0]  gap_len;
    logic [ADDR_W-1:0] win_start;
    logic [ADDR_W-1:0] win_end;
    logic [63:0]       bsn_init;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;

    bwg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .en           (en),
        .blk_len      (blk_len),
        .blk_per_sync (blk_per_sync),
        .gap_len      (gap_len),
        .win_start    (win_start),
        .win_end      (win_end),
        .bsn_init     (bsn_init)
    );

    bwg_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .blk_len      (blk_len),
        .blk_per_sync (blk_per_sync),
        .gap_len      (gap_len),
        .win_start    (win_start),
        .win_end      (win_end),
        .bsn_init     (bsn_init),
        .ready        (out_ready),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .o_valid      (out_valid),
        .o_sop        (out_sop),
        .o_eop        (out_eop),
        .o_sync       (out_sync),
        .o_bsn        (out_bsn)
    );

    // One buffer per stream, all read at the shared address
    for (genvar s = 0; s < NSTR; s++) begin : g_stream
        bwg_buf #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (buf_wr && (buf_sel == SEL_W'(s))),
            .wr_addr (buf_addr),
            .wr_data (buf_wdata),
            .rd_en   (rd_en),
            .rd_addr (rd_addr),
            .rd_re   (out_re[s*SAMP_W +: SAMP_W]),
            .rd_im   (out_im[s*SAMP_W +: SAMP_W])
        );
    end

    // R9: a stalled edge yields no sample
    p_stall_blocks_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> !out_valid);

endmodule

// File: tb/blkwave_gen_tb.sv
// Bench: directed and seeded random runs checked against a bench-side stream model.
module blkwave_gen_tb;

    localparam int NSTR = 2;
    localparam int SW   = 16;
    localparam int AW   = 6;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic buf_wr = 1'b0;
    logic [0:0] buf_sel = '0;
    logic [AW-1:0] buf_addr = '0;
    logic [31:0] buf_wdata = '0;
    logic out_ready = 1'b1;
    logic out_valid, out_sop, out_eop, out_sync;
    logic [63:0] out_bsn;
    logic [NSTR*SW-1:0] out_re, out_im;

    always #5 clk = ~clk;

    blkwave_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .buf_wr(buf_wr), .buf_sel(buf_sel),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_sync(out_sync), .out_bsn(out_bsn), .out_re(out_re), .out_im(out_im)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Model state
    int m_len = 1, m_bps = 1, m_gap = 0, m_start = 0, m_end = 63, m_salt = 0;
    int m_addr = 0, m_samp = 0, m_blk = 0, m_idle = 0, m_nvalid = 0;
    bit m_first = 1'b1, m_strict = 1'b1;
    logic [63:0] m_bsn = '0, m_bsn0 = '0;
    int rdy_pct = 100;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int s, input int a, input int salt);
        logic [31:0] v;
        v = 32'(a) * 32'h0000_9E37 + 32'(s) * 32'h7F4A_7C15 + 32'(salt) * 32'h0123_4567;
        return v ^ {v[15:0], v[31:16]};
    endfunction

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic void summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endfunction

    // Monitor, model and ready driver, all away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc > WD) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, WD);
                summary();
                $finish;
            end
            if (!out_ready)
                chk(!out_valid, "R9", "valid after stalled edge", 64'(out_valid), 0);
            if (out_valid) begin
                bit exp_eop;
                exp_eop = (m_samp + 1 >= eff(m_len));
                for (int s = 0; s < NSTR; s++) begin
                    logic [31:0] w;
                    w = pat(s, m_addr, m_salt);
                    chk(out_re[s*SW +: SW] == w[31:16], "R4 R10", "real", 64'(out_re[s*SW +: SW]), 64'(w[31:16]));
                    chk(out_im[s*SW +: SW] == w[15:0], "R4 R10", "imag", 64'(out_im[s*SW +: SW]), 64'(w[15:0]));
                end
                chk(out_sop == (m_samp == 0), "R3", "sop", 64'(out_sop), 64'(m_samp == 0));
                chk(out_eop == exp_eop, "R3", "eop", 64'(out_eop), 64'(exp_eop));
                chk(out_sync == (m_samp == 0 && m_blk == 0), "R5", "sync", 64'(out_sync), 64'(m_samp == 0 && m_blk == 0));
                chk(out_bsn == m_bsn, "R7", "bsn", out_bsn, m_bsn);
                if (m_first)
                    chk(out_bsn == m_bsn0, "R2 R11", "initial bsn", out_bsn, m_bsn0);
                else if (m_samp == 0) begin
                    if (m_strict) chk(m_idle == m_gap, "R6", "gap exact", 64'(m_idle), 64'(m_gap));
                    else          chk(m_idle >= m_gap, "R6", "gap minimum", 64'(m_idle), 64'(m_gap));
                end
                m_idle = 0;
                m_first = 1'b0;
                m_nvalid++;
                m_addr = (m_addr == m_end) ? m_start : (m_addr + 1) % 64;
                if (exp_eop) begin
                    m_samp = 0;
                    m_bsn = m_bsn + 64'd1;
                    m_blk = (m_blk + 1 >= eff(m_bps)) ? 0 : m_blk + 1;
                end else m_samp++;
            end else begin
                chk(!out_sop && !out_eop && !out_sync, "R12", "flags while idle",
                    {61'd0, out_sop, out_eop, out_sync}, 0);
                m_idle++;
            end
            out_ready <= (($urandom % 100) < 32'(rdy_pct));
        end
    end

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_bufs(input int salt);
        for (int s = 0; s < NSTR; s++)
            for (int a = 0; a < 64; a++) begin
                @(negedge clk);
                buf_wr = 1'b1; buf_sel = 1'(s); buf_addr = AW'(a); buf_wdata = pat(s, a, salt);
            end
        @(negedge clk);
        buf_wr = 1'b0;
        m_salt = salt;
    endtask

    // One run: program, enable, wait, disable, then check the stop
    task automatic run(input int len, input int bps, input int gap, input int st,
                       input int en_, input logic [63:0] b0, input int pct, input int cycles);
        int nv;
        rdy_pct = pct;
        m_strict = (pct == 100);
        cfg_write(1, 32'(len));
        cfg_write(2, 32'(bps));
        cfg_write(3, 32'(gap));
        cfg_write(4, 32'(st));
        cfg_write(5, 32'(en_));
        cfg_write(6, b0[31:0]);
        cfg_write(7, b0[63:32]);
        m_len = len; m_bps = bps; m_gap = gap; m_start = st; m_end = en_;
        m_addr = st; m_samp = 0; m_blk = 0; m_bsn = b0; m_bsn0 = b0; m_first = 1'b1;
        m_nvalid = 0;
        cfg_write(0, 32'd1);
        repeat (cycles) @(negedge clk);
        cfg_write(0, 32'd0);
        repeat (300) @(negedge clk);
        chk(m_nvalid > 0, "R2", "samples emitted", 64'(m_nvalid), 1);
        chk(m_samp == 0, "R8", "stopped at block end", 64'(m_samp), 0);
        nv = m_nvalid;
        repeat (40) @(negedge clk);
        chk(m_nvalid == nv, "R8", "no samples after stop", 64'(m_nvalid), 64'(nv));
        rdy_pct = 100;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sop && !out_eop && !out_sync, "R1", "outputs in reset",
            {60'd0, out_valid, out_sop, out_eop, out_sync}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_sop && !out_eop && !out_sync, "R1", "outputs after reset",
            {60'd0, out_valid, out_sop, out_eop, out_sync}, 0);

        load_bufs(1);
        // R2 R7: bsn carries from low word into high word
        run(4, 3, 0, 2, 9, 64'h0000_0001_FFFF_FFFE, 100, 61);
        // R6: exact gap of three idle cycles
        run(5, 2, 3, 10, 20, 64'h10, 100, 80);
        // R3 R5: zero length and sync count act as one
        run(0, 0, 1, 0, 5, 64'h55, 100, 30);
        // R11: restart with the same registers reloads the run
        run(3, 2, 0, 40, 63, 64'hABCD, 100, 25);

        for (int i = 0; i < 36; i++) begin
            int st, en_, pct;
            st  = $urandom % 64;
            en_ = st + ($urandom % (64 - st));
            pct = (i % 3 == 0) ? 100 : 50 + ($urandom % 40);
            if (i % 4 == 0) load_bufs(i + 2);
            run(1 + $urandom % 12, 1 + $urandom % 5, $urandom % 5, st, en_,
                {$urandom, $urandom}, pct, 20 + $urandom % 150);
        end

        summary();
        $finish;
    end

endmodule